// File: doc/BRIEF.md
# Serial Identification Memory Slave

This block answers a host on a two-wire serial bus with a 128-byte read-only identification image, in the way a small serial EEPROM does. The system clock oversamples the bus lines, and the block sees the START and STOP conditions and the clock edges on the synchronised copies. It replies only to the 7-bit device select 1010000b. The host sets the pointer with a word address, then issues a repeated START and reads bytes one after another. Each byte the host acknowledges moves the pointer on by one.

Most of the image is fixed. Two areas come from input ports: a 16-byte serial number and an 8-byte date code. One byte follows a variant strap. Logic derives the two checksum bytes from the image as it reads, so no stored sum can fall out of date when the port-loaded fields change. The host may write to the block: every byte is acknowledged and only the word address takes effect.

Top module: `sid_mem_slave`

## Requirements
- R1: After reset the block does not pull SDA low (`sda_oe_o` is 0).
- R2: A device byte whose upper seven bits are 1010000b, with the R/W flag in bit 0, is acknowledged. Any other device byte gets no acknowledge, and SDA stays released until the next START.
- R3: A random read returns the byte at the word address. The sequence is a write select, the word address, a repeated START and a read select. Data goes out MSB first and changes only while SCL is low.
- R4: While the host acknowledges, a read goes on with the next address, and address 127 is followed by address 0. A host NACK ends the read.
- R5: The pointer keeps its value across a STOP. A read select with no word address before it continues from where the last access left off.
- R6: The fixed bytes read as (address XOR A5h). They are addresses 0–62 except 47, 64–67 and 92–94. Addresses 96–127 read 00h.
- R7: Address 47 reads 30h when `variant_i` is 0 and 31h when it is 1.
- R8: Addresses 68–83 return `serial_id_i`, most significant byte first (address 68 is bits 127:120). Addresses 84–91 return `date_code_i` the same way (address 84 is bits 63:56).
- R9: Address 63 reads the low 8 bits of the sum of the bytes at addresses 0–62.
- R10: Address 95 reads the low 8 bits of the sum of the bytes at addresses 64–94.
- R11: In a write, the device byte, the word address and every data byte are acknowledged. The data bytes change no content, and the word address becomes the pointer.
- R12: A START at any point, including partway through a byte, restarts device-byte reception. A STOP returns the block to idle with SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, oversamples the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| variant_i | input | 1 | Strap that selects the value of address 47 |
| serial_id_i | input | 128 | Serial number field |
| date_code_i | input | 64 | Date code field |

## Verification
A wrong pointer shows up on the first byte read after the word address. A wrong wrap or increment shows up on the byte that follows address 127. An error in the bit engine's state shows up at once as a missing acknowledge or as SDA held low where the host expects it released, and the bench samples the line on every ninth SCL pulse. An error in the checksum logic or the field mapping shows up as a wrong byte at 47, 63, 95 or in the loaded ranges. These are read after the serial number, the date code and the strap have been changed.

// File: rtl/sid_pkg.sv
package sid_pkg;
  localparam int MEM_BYTES = 128;
  localparam int AW        = $clog2(MEM_BYTES);
  localparam logic [6:0] DEV_SEL = 7'h50;
  localparam int VAR_ADDR  = 47;
  localparam int CS0_ADDR  = 63;
  localparam int CS1_ADDR  = 95;
  localparam int SER_BASE  = 68;
  localparam int SER_LEN   = 16;
  localparam int DATE_BASE = 84;
  localparam int DATE_LEN  = 8;
  localparam int ZERO_BASE = 96;
  localparam int SER_BITS  = SER_LEN * 8;
  localparam int DATE_BITS = DATE_LEN * 8;
  localparam logic [7:0] FILL_XOR  = 8'hA5;
  localparam logic [7:0] VAR_CHAR0 = 8'h30;

  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK} sid_state_e;
  typedef enum logic [1:0] {K_DEV, K_ADDR, K_WDATA} sid_kind_e;
endpackage

// File: rtl/sid_line_sync.sv
module sid_line_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [2:0] scl_s, sda_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_s <= '1;
      sda_s <= '1;
    end else begin
      scl_s <= {scl_s[1:0], scl_i};
      sda_s <= {sda_s[1:0], sda_i};
    end
  end

  assign sda_o      = sda_s[1];
  assign scl_rise_o = scl_s[1] & ~scl_s[2];
  assign scl_fall_o = ~scl_s[1] & scl_s[2];
  // data edges while the clock stays high are bus conditions
  assign start_o    = scl_s[1] & scl_s[2] & ~sda_s[1] & sda_s[2];
  assign stop_o     = scl_s[1] & scl_s[2] & sda_s[1] & ~sda_s[2];
endmodule

// File: rtl/sid_image.sv
module sid_image
  import sid_pkg::*;
(
  input  logic [AW-1:0]        addr_i,
  input  logic                 variant_i,
  input  logic [SER_BITS-1:0]  serial_id_i,
  input  logic [DATE_BITS-1:0] date_code_i,
  output logic [7:0]           data_o
);
  logic [7:0] img [MEM_BYTES];
  logic [7:0] cs0, cs1;

  for (genvar g = 0; g < MEM_BYTES; g++) begin : g_img
    if (g == VAR_ADDR) begin : g_var
      assign img[g] = VAR_CHAR0 | {7'd0, variant_i};
    end else if (g >= SER_BASE && g < SER_BASE + SER_LEN) begin : g_ser
      assign img[g] = serial_id_i[SER_BITS-1-8*(g-SER_BASE) -: 8];
    end else if (g >= DATE_BASE && g < DATE_BASE + DATE_LEN) begin : g_date
      assign img[g] = date_code_i[DATE_BITS-1-8*(g-DATE_BASE) -: 8];
    end else if (g == CS0_ADDR || g == CS1_ADDR || g >= ZERO_BASE) begin : g_zero
      assign img[g] = 8'h00;
    end else begin : g_fill
      assign img[g] = 8'(g) ^ FILL_XOR;
    end
  end

  always_comb begin
    cs0 = '0;
    for (int i = 0; i < CS0_ADDR; i++) cs0 = cs0 + img[i];
    cs1 = '0;
    for (int i = CS0_ADDR + 1; i < CS1_ADDR; i++) cs1 = cs1 + img[i];
  end

  always_comb begin
    if (addr_i == AW'(CS0_ADDR))      data_o = cs0;
    else if (addr_i == AW'(CS1_ADDR)) data_o = cs1;
    else                              data_o = img[addr_i];
  end
endmodule

// File: rtl/sid_engine.sv
module sid_engine
  import sid_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sda_i,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic [7:0]    rd_data_i,
  output logic [AW-1:0] rd_addr_o,
  output logic          sda_oe_o
);
  sid_state_e    st_q;
  sid_kind_e     kind_q;
  logic [3:0]    cnt_q;
  logic [7:0]    sh_q;
  logic [AW-1:0] ptr_q;
  logic          rw_q, mack_q, oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      kind_q <= K_DEV;
      cnt_q  <= '0;
      sh_q   <= '0;
      ptr_q  <= '0;
      rw_q   <= 1'b0;
      mack_q <= 1'b0;
      oe_q   <= 1'b0;
    end else if (start_i) begin
      st_q   <= ST_RX;
      kind_q <= K_DEV;
      cnt_q  <= '0;
      oe_q   <= 1'b0;
    end else if (stop_i) begin
      st_q <= ST_IDLE;
      oe_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_RX: begin
          if (scl_rise_i && cnt_q != 4'd8) begin
            sh_q  <= {sh_q[6:0], sda_i};
            cnt_q <= cnt_q + 4'd1;
          end else if (scl_fall_i && cnt_q == 4'd8) begin
            unique case (kind_q)
              K_DEV: begin
                if (sh_q[7:1] == DEV_SEL) begin
                  rw_q <= sh_q[0];
                  st_q <= ST_ACK;
                  oe_q <= 1'b1;
                end else begin
                  st_q <= ST_IDLE;
                end
              end
              K_ADDR: begin
                ptr_q <= sh_q[AW-1:0];
                st_q  <= ST_ACK;
                oe_q  <= 1'b1;
              end
              default: begin
                st_q <= ST_ACK;
                oe_q <= 1'b1;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall_i) begin
            cnt_q <= '0;
            if (kind_q == K_DEV && rw_q) begin
              st_q <= ST_TX;
              sh_q <= rd_data_i;
              oe_q <= ~rd_data_i[7];
            end else begin
              st_q   <= ST_RX;
              oe_q   <= 1'b0;
              kind_q <= (kind_q == K_DEV) ? K_ADDR : K_WDATA;
            end
          end
        end
        ST_TX: begin
          if (scl_fall_i) begin
            if (cnt_q == 4'd7) begin
              st_q  <= ST_MACK;
              oe_q  <= 1'b0;
              ptr_q <= ptr_q + 1'b1;
            end else begin
              cnt_q <= cnt_q + 4'd1;
              sh_q  <= {sh_q[6:0], 1'b0};
              oe_q  <= ~sh_q[6];
            end
          end
        end
        ST_MACK: begin
          if (scl_rise_i) begin
            mack_q <= ~sda_i;
          end else if (scl_fall_i) begin
            if (mack_q) begin
              st_q  <= ST_TX;
              cnt_q <= '0;
              sh_q  <= rd_data_i;
              oe_q  <= ~rd_data_i[7];
            end else begin
              st_q <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign rd_addr_o = ptr_q;
  assign sda_oe_o  = oe_q;

  assert_idle_release_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE) |-> !oe_q);
  assert_start_rx_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (st_q == ST_RX && kind_q == K_DEV && cnt_q == 4'd0 && !oe_q));
  assert_stop_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !start_i) |=> (st_q == ST_IDLE));
  assert_oe_on_fall_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(oe_q) |-> $past(scl_fall_i || start_i || stop_i));
  assert_ptr_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_TX && scl_fall_i && cnt_q == 4'd7 && !start_i && !stop_i)
    |=> (rd_addr_o == AW'($past(rd_addr_o) + 1'b1)));
endmodule

// File: rtl/sid_mem_slave.sv
module sid_mem_slave
  import sid_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 scl_i,
  input  logic                 sda_i,
  output logic                 sda_oe_o,
  input  logic                 variant_i,
  input  logic [SER_BITS-1:0]  serial_id_i,
  input  logic [DATE_BITS-1:0] date_code_i
);
  logic          sda_s, scl_rise, scl_fall, start, stop;
  logic [AW-1:0] rd_addr;
  logic [7:0]    rd_data;

  sid_line_sync i_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start), .stop_o(stop)
  );

  sid_image i_image (
    .addr_i(rd_addr), .variant_i, .serial_id_i, .date_code_i, .data_o(rd_data)
  );

  sid_engine i_engine (
    .clk_i, .rst_ni, .sda_i(sda_s), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start), .stop_i(stop), .rd_data_i(rd_data),
    .rd_addr_o(rd_addr), .sda_oe_o
  );
endmodule

// File: tb/test_sid_mem_slave.sv
module test_sid_mem_slave;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 6;

  logic clk_i = 1'b0, rst_ni = 1'b0, scl = 1'b1, sda_host = 1'b1;
  logic sda_oe_o, variant = 1'b0;
  logic [127:0] serial = '0;
  logic [63:0]  date = '0;
  wire sda_line = sda_host & ~sda_oe_o;
  int nchk = 0, nerr = 0, oe_hits = 0;
  bit watch = 0, done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;
  always @(posedge clk_i) if (watch && sda_oe_o) oe_hits++;

  sid_mem_slave i_sid_mem_slave (
    .clk_i, .rst_ni, .scl_i(scl), .sda_i(sda_line), .sda_oe_o,
    .variant_i(variant), .serial_id_i(serial), .date_code_i(date)
  );

  function automatic logic [7:0] plain(int a);
    if (a == 47) return 8'h30 + {7'd0, variant};
    if (a >= 68 && a <= 83) return serial[127-8*(a-68) -: 8];
    if (a >= 84 && a <= 91) return date[63-8*(a-84) -: 8];
    if (a == 63 || a == 95 || a >= 96) return 8'h00;
    return 8'(a) ^ 8'hA5;
  endfunction

  function automatic logic [7:0] exp_byte(int a);
    logic [7:0] s = 0;
    if (a == 63) begin for (int i = 0; i < 63; i++) s += plain(i); return s; end
    if (a == 95) begin for (int i = 64; i < 95; i++) s += plain(i); return s; end
    return plain(a);
  endfunction

  function automatic string tag_of(int a);
    if (a == 47) return "R7";
    if (a == 63) return "R9";
    if (a == 95) return "R10";
    if (a >= 68 && a <= 91) return "R8";
    return "R6";
  endfunction

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic bus_start;
    sda_host = 1'b1; hold(Q); scl = 1'b1; hold(Q);
    sda_host = 1'b0; hold(Q); scl = 1'b0; hold(Q);
  endtask

  task automatic bus_stop;
    sda_host = 1'b0; hold(Q); scl = 1'b1; hold(Q); sda_host = 1'b1; hold(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_host = b[i]; hold(Q); scl = 1'b1; hold(2*Q); scl = 1'b0; hold(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_host = 1'b1; hold(Q); scl = 1'b1; hold(Q);
    ack = ~sda_line; hold(Q); scl = 1'b0; hold(Q);
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    sda_host = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hold(Q); scl = 1'b1; hold(Q); b[i] = sda_line; hold(Q); scl = 1'b0;
    end
    hold(Q); sda_host = ~give_ack; hold(Q); scl = 1'b1; hold(2*Q);
    scl = 1'b0; hold(Q); sda_host = 1'b1;
  endtask

  task automatic rand_read(input int addr, input int n);
    logic ack;
    logic [7:0] b;
    bus_start;
    send_byte(8'hA0, ack); check({7'd0, ack}, 8'd1, "R2 write select ack");
    send_byte(8'(addr), ack); check({7'd0, ack}, 8'd1, "R3 word address ack");
    bus_start;
    send_byte(8'hA1, ack); check({7'd0, ack}, 8'd1, "R3 read select ack");
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, b);
      check(b, exp_byte((addr + i) % 128), tag_of((addr + i) % 128));
    end
    bus_stop;
  endtask

  initial begin
    logic ack;
    logic [7:0] b, dev;
    int seed_init;
    seed_init = $urandom(32'h5eed);
    hold(3);
    check({7'd0, sda_oe_o}, 8'd0, "R1 released in reset");
    rst_ni = 1'b1; hold(4);
    check({7'd0, sda_oe_o}, 8'd0, "R1 released after reset");

    serial = {$urandom, $urandom, $urandom, $urandom};
    date = {$urandom, $urandom};
    rand_read(40, 10);          // R3 R6 R7 around the strap byte
    variant = 1'b1;
    rand_read(45, 4);           // R7 with the strap set
    rand_read(0, 128);          // R4 full sweep with R6 R8 R9 R10
    serial = {$urandom, $urandom, $urandom, $urandom};
    date = {$urandom, $urandom};
    variant = 1'b0;
    rand_read(60, 40);          // R9 R10 recomputed after field change

    // R4 wrap 127 -> 0
    bus_start; send_byte(8'hA0, ack); send_byte(8'd126, ack);
    bus_start; send_byte(8'hA1, ack);
    for (int i = 0; i < 4; i++) begin
      recv_byte(i != 3, b);
      check(b, exp_byte((126 + i) % 128), "R4 wrap");
    end
    bus_stop;
    // R5 current address read continues at 2
    bus_start; send_byte(8'hA1, ack); check({7'd0, ack}, 8'd1, "R5 read select ack");
    recv_byte(1'b0, b); check(b, exp_byte(2), "R5 current address");
    bus_stop;

    // R2 foreign device bytes
    for (int k = 0; k < 5; k++) begin
      dev = (k == 0) ? 8'hA2 : 8'($urandom);
      if (dev[7:1] == 7'h50) dev = 8'hB0;
      bus_start; send_byte(dev, ack);
      check({7'd0, ack}, 8'd0, "R2 foreign device nack");
      oe_hits = 0; watch = 1;
      send_byte(8'h00, ack); send_byte(8'hA0, ack);
      watch = 0;
      check(8'(oe_hits), 8'd0, "R2 line released until start");
      bus_stop;
    end

    // R11 writes are acknowledged and ignored
    bus_start; send_byte(8'hA0, ack); check({7'd0, ack}, 8'd1, "R11 select ack");
    send_byte(8'd10, ack); check({7'd0, ack}, 8'd1, "R11 address ack");
    for (int i = 0; i < 3; i++) begin
      send_byte(8'hFF, ack); check({7'd0, ack}, 8'd1, "R11 data ack");
    end
    bus_stop;
    bus_start; send_byte(8'hA1, ack);
    recv_byte(1'b1, b); check(b, exp_byte(10), "R11 content unchanged");
    recv_byte(1'b0, b); check(b, exp_byte(11), "R11 content unchanged");
    bus_stop;

    // R12 start partway through a byte
    bus_start; send_bits(8'hA0, 5);
    scl = 1'b0; hold(Q);
    bus_start; send_byte(8'hA0, ack); check({7'd0, ack}, 8'd1, "R12 restart select ack");
    send_byte(8'd68, ack); bus_start; send_byte(8'hA1, ack);
    recv_byte(1'b0, b); check(b, exp_byte(68), "R12 read after restart");
    bus_stop;
    check({7'd0, sda_oe_o}, 8'd0, "R12 released after stop");

    for (int k = 0; k < 8; k++) begin
      variant = 1'($urandom);
      serial[31:0] = $urandom;
      rand_read($urandom % 128, 1 + ($urandom % 5));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog expired actual running expected done");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end
endmodule